// File: doc/BRIEF.md
# Store-to-Load Memory Operand Bypass

This block sits between a single in-order execution pipeline and its data cache. When an instruction that writes a 32-bit result to memory reaches write-back, the result is parked in a small ordered queue of pending writes until the cache accepts it. A later instruction may ask for a memory operand at the same doubleword address. If so, the block supplies the pending result directly and holds back the cache read. The dependent pair then completes without a round trip through memory.

Each pending write carries a doubleword address, 32 data bits and four byte enables. Byte lane k is data bits 8k+7:8k and is enabled by enable bit k. A write enters the queue as uncommitted. Commit pulses mark entries as committed, oldest first. Only committed entries are offered to the cache, one at a time, in program order. A pipeline flush discards every entry that has not been committed. A read is forwarded only when the youngest pending write to its address holds every byte the read needs. If that write holds only some of the bytes, the read stalls. If no pending write matches, the read goes to the cache.

Top module: `mem_operand_bypass`

## Requirements
- R1: After reset the queue is empty: `wb_ready` is 1, `cache_wr_valid` is 0, `fwd_valid` is 0, and `cache_rd_en` and `rd_stall` are 0 while `rd_req` is 0.
- R2: A write is accepted in a cycle where `wb_valid` and `wb_ready` are 1 and `pipe_flush` is 0. `wb_ready` is 0 exactly when DEPTH entries are pending, and a write offered then is dropped.
- R3: A read whose address equals a pending entry's address, and whose `rd_be` bits are all set in that entry's enables, raises `fwd_valid` in the next cycle. `fwd_data` then carries the entry's data, with every byte lane whose `rd_be` bit is 0 set to zero.
- R4: In a cycle with `rd_req` at 1, exactly one of three outcomes occurs: forward, `rd_stall`, or `cache_rd_en`. `cache_rd_en` is 1 only when no pending entry and no write accepted in that cycle has the read's address, and then `cache_rd_addr` equals `rd_addr`. With `rd_req` at 0, `cache_rd_en` and `rd_stall` are 0.
- R5: When several pending entries match a read, only the youngest one decides the outcome and supplies the data.
- R6: When the youngest matching entry lacks any byte set in `rd_be`, `rd_stall` is 1 in that cycle. No forward follows and no cache read is issued, even if an older entry holds those bytes.
- R7: A write accepted in the same cycle as a matching read counts as the youngest entry. Its result appears on `fwd_data` one cycle after both were presented, so the pair completes in two cycles.
- R8: `wb_commit` marks the oldest uncommitted entry as committed and is ignored when there is none. `cache_wr_valid` is 1 exactly when a committed entry exists, and `cache_wr_addr`, `cache_wr_data` and `cache_wr_be` show the oldest entry.
- R9: The oldest entry leaves the queue only in a cycle where `cache_wr_valid` and `cache_wr_ready` are both 1. Until then the offered write stays unchanged.
- R10: `pipe_flush` discards every entry still uncommitted after that cycle's commit, and it also discards the write offered in that cycle. Committed entries remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_valid | input | 1 | Write-back offers a pending memory write |
| wb_addr | input | ADDR_W | Doubleword address of the offered write |
| wb_data | input | 32 | Result data of the offered write |
| wb_be | input | 4 | Byte enables of the offered write |
| wb_ready | output | 1 | Queue can take a write |
| wb_commit | input | 1 | Commit the oldest uncommitted entry |
| pipe_flush | input | 1 | Discard uncommitted entries and the offered write |
| rd_req | input | 1 | Address stage requests a memory operand |
| rd_addr | input | ADDR_W | Doubleword address of the operand |
| rd_be | input | 4 | Bytes the operand needs |
| fwd_valid | output | 1 | Forwarded operand valid (one cycle after the request) |
| fwd_data | output | 32 | Forwarded operand data, unneeded bytes zero |
| rd_stall | output | 1 | Partial overlap: retry the read later |
| cache_rd_en | output | 1 | Read the operand from the cache |
| cache_rd_addr | output | ADDR_W | Address for the cache read |
| cache_wr_valid | output | 1 | Oldest committed write offered to the cache |
| cache_wr_addr | output | ADDR_W | Address of the offered cache write |
| cache_wr_data | output | 32 | Data of the offered cache write |
| cache_wr_be | output | 4 | Byte enables of the offered cache write |
| cache_wr_ready | input | 1 | Cache accepts the offered write |

## Verification
The bench builds the block with DEPTH=4 and ADDR_W=8, and draws read and write addresses from a pool of four doublewords. With four entries the queue fills after a handful of writes, so the full condition and dropped writes come up often. The small address pool makes multiple matches, youngest-entry selection, partial overlaps and same-cycle forwarding frequent under random traffic. Random commit, flush and cache-ready patterns mix committed and uncommitted entries, so flushes regularly cut the queue in the middle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_DATA_W = 32;
  localparam int unsigned SB_BE_W   = SB_DATA_W / 8;

  // Outcome of searching the pending writes for one operand read
  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_HIT     = 2'd1,
    LK_PARTIAL = 2'd2
  } lookup_e;

  // Expand byte enables to a bit mask, lane k = bits 8k+7:8k
  function automatic logic [SB_DATA_W-1:0] lane_mask(input logic [SB_BE_W-1:0] be);
    for (int k = 0; k < int'(SB_BE_W); k++) begin
      lane_mask[8*k +: 8] = {8{be[k]}};
    end
  endfunction
endpackage

// File: rtl/sb_pending_queue.sv
// Ordered ring of pending memory writes. Entries enter uncommitted, commit
// oldest-first, drain to the cache from the head. DEPTH is a power of two, >= 2.
module sb_pending_queue
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enq_i,
  input  logic [ADDR_W-1:0]                 enq_addr_i,
  input  logic [SB_DATA_W-1:0]              enq_data_i,
  input  logic [SB_BE_W-1:0]                enq_be_i,
  input  logic                              commit_i,
  input  logic                              flush_i,
  input  logic                              drain_rdy_i,
  output logic                              full_o,
  output logic                              drain_vld_o,
  output logic [ADDR_W-1:0]                 drain_addr_o,
  output logic [SB_DATA_W-1:0]              drain_data_o,
  output logic [SB_BE_W-1:0]                drain_be_o,
  output logic [DEPTH-1:0]                  ord_vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]      ord_addr_o,
  output logic [DEPTH-1:0][SB_DATA_W-1:0]   ord_data_o,
  output logic [DEPTH-1:0][SB_BE_W-1:0]     ord_be_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0]    addr_q [DEPTH];
  logic [SB_DATA_W-1:0] data_q [DEPTH];
  logic [SB_BE_W-1:0]   be_q   [DEPTH];

  logic [PTR_W-1:0] head_q, head_d, tail;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] ncommit_q, ncommit_d;
  logic             pop, cm;

  assign tail        = head_q + PTR_W'(count_q);
  assign full_o      = (count_q == CNT_W'(DEPTH));
  assign drain_vld_o = (ncommit_q != '0);
  assign drain_addr_o = addr_q[head_q];
  assign drain_data_o = data_q[head_q];
  assign drain_be_o   = be_q[head_q];

  // Next state
  always_comb begin
    pop       = drain_vld_o & drain_rdy_i;
    cm        = commit_i & (ncommit_q < count_q);
    ncommit_d = ncommit_q + CNT_W'(cm) - CNT_W'(pop);
    head_d    = head_q + PTR_W'(pop);
    if (flush_i) begin
      count_d = ncommit_d;
    end else begin
      count_d = count_q + CNT_W'(enq_i) - CNT_W'(pop);
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      count_q   <= '0;
      ncommit_q <= '0;
    end else begin
      head_q    <= head_d;
      count_q   <= count_d;
      ncommit_q <= ncommit_d;
    end
  end

  // Entry storage, written only at the tail slot when a write is accepted
  always_ff @(posedge clk) begin
    if (enq_i) begin
      addr_q[tail] <= enq_addr_i;
      data_q[tail] <= enq_data_i;
      be_q[tail]   <= enq_be_i;
    end
  end

  // Present the entries oldest first
  for (genvar i = 0; i < DEPTH; i++) begin : g_ord
    logic [PTR_W-1:0] slot;
    assign slot          = head_q + PTR_W'(i);
    assign ord_vld_o[i]  = (count_q > CNT_W'(i));
    assign ord_addr_o[i] = addr_q[slot];
    assign ord_data_o[i] = data_q[slot];
    assign ord_be_o[i]   = be_q[slot];
  end

  // R2: the top never pushes into a full queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i |-> !full_o);

  // R8: committed entries never outnumber pending entries
  p_commit_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ncommit_q <= count_q);

  // R9: an unaccepted cache write is held unchanged
  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_vld_o && !drain_rdy_i) |=>
      (drain_vld_o && $stable(drain_addr_o) && $stable(drain_data_o) && $stable(drain_be_o)));

  // R10: after a flush only committed entries remain
  p_flush_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (ncommit_q == count_q));
endmodule

// File: rtl/sb_match.sv
// Youngest-match search over the pending writes plus the write accepted this cycle.
module sb_match
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DEPTH  = 4
) (
  input  logic [DEPTH-1:0]                ord_vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]    ord_addr_i,
  input  logic [DEPTH-1:0][SB_DATA_W-1:0] ord_data_i,
  input  logic [DEPTH-1:0][SB_BE_W-1:0]   ord_be_i,
  input  logic                            inc_vld_i,
  input  logic [ADDR_W-1:0]               inc_addr_i,
  input  logic [SB_DATA_W-1:0]            inc_data_i,
  input  logic [SB_BE_W-1:0]              inc_be_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  input  logic [SB_BE_W-1:0]              rd_be_i,
  output lookup_e                         look_o,
  output logic [SB_DATA_W-1:0]            data_o
);
  logic                 found;
  logic [SB_BE_W-1:0]   y_be;
  logic [SB_DATA_W-1:0] y_data;

  always_comb begin
    found  = 1'b0;
    y_be   = '0;
    y_data = '0;
    // Oldest to youngest: a later match overrides an earlier one
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (ord_vld_i[i] && (ord_addr_i[i] == rd_addr_i)) begin
        found  = 1'b1;
        y_be   = ord_be_i[i];
        y_data = ord_data_i[i];
      end
    end
    if (inc_vld_i && (inc_addr_i == rd_addr_i)) begin
      found  = 1'b1;
      y_be   = inc_be_i;
      y_data = inc_data_i;
    end
    if (!found) begin
      look_o = LK_MISS;
    end else if ((rd_be_i & ~y_be) == '0) begin
      look_o = LK_HIT;
    end else begin
      look_o = LK_PARTIAL;
    end
    data_o = y_data & lane_mask(rd_be_i);
  end
endmodule

// File: rtl/mem_operand_bypass.sv
module mem_operand_bypass
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wb_valid,
  input  logic [ADDR_W-1:0]     wb_addr,
  input  logic [SB_DATA_W-1:0]  wb_data,
  input  logic [SB_BE_W-1:0]    wb_be,
  output logic                  wb_ready,
  input  logic                  wb_commit,
  input  logic                  pipe_flush,
  input  logic                  rd_req,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [SB_BE_W-1:0]    rd_be,
  output logic                  fwd_valid,
  output logic [SB_DATA_W-1:0]  fwd_data,
  output logic                  rd_stall,
  output logic                  cache_rd_en,
  output logic [ADDR_W-1:0]     cache_rd_addr,
  output logic                  cache_wr_valid,
  output logic [ADDR_W-1:0]     cache_wr_addr,
  output logic [SB_DATA_W-1:0]  cache_wr_data,
  output logic [SB_BE_W-1:0]    cache_wr_be,
  input  logic                  cache_wr_ready
);
  logic                           full, enq, hit;
  logic [DEPTH-1:0]               ord_vld;
  logic [DEPTH-1:0][ADDR_W-1:0]   ord_addr;
  logic [DEPTH-1:0][SB_DATA_W-1:0] ord_data;
  logic [DEPTH-1:0][SB_BE_W-1:0]  ord_be;
  lookup_e                        look;
  logic [SB_DATA_W-1:0]           sel_data;
  logic                           fwd_valid_d;
  logic [SB_DATA_W-1:0]           fwd_data_d;

  assign wb_ready = ~full;
  assign enq      = wb_valid & ~full & ~pipe_flush;

  sb_pending_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_i        (enq),
    .enq_addr_i   (wb_addr),
    .enq_data_i   (wb_data),
    .enq_be_i     (wb_be),
    .commit_i     (wb_commit),
    .flush_i      (pipe_flush),
    .drain_rdy_i  (cache_wr_ready),
    .full_o       (full),
    .drain_vld_o  (cache_wr_valid),
    .drain_addr_o (cache_wr_addr),
    .drain_data_o (cache_wr_data),
    .drain_be_o   (cache_wr_be),
    .ord_vld_o    (ord_vld),
    .ord_addr_o   (ord_addr),
    .ord_data_o   (ord_data),
    .ord_be_o     (ord_be)
  );

  sb_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
    .ord_vld_i  (ord_vld),
    .ord_addr_i (ord_addr),
    .ord_data_i (ord_data),
    .ord_be_i   (ord_be),
    .inc_vld_i  (enq),
    .inc_addr_i (wb_addr),
    .inc_data_i (wb_data),
    .inc_be_i   (wb_be),
    .rd_addr_i  (rd_addr),
    .rd_be_i    (rd_be),
    .look_o     (look),
    .data_o     (sel_data)
  );

  assign hit           = rd_req & (look == LK_HIT);
  assign rd_stall      = rd_req & (look == LK_PARTIAL);
  assign cache_rd_en   = rd_req & (look == LK_MISS);
  assign cache_rd_addr = rd_addr;

  // Forward response: next state
  always_comb begin
    fwd_valid_d = hit;
    fwd_data_d  = fwd_data;
    if (hit) begin
      fwd_data_d = sel_data;
    end
  end

  // Forward response: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= fwd_valid_d;
      fwd_data  <= fwd_data_d;
    end
  end

  // R4: a request takes exactly one path
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ($countones({hit, rd_stall, cache_rd_en}) == 1));

  // R4: no request, no cache read and no stall
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> (!cache_rd_en && !rd_stall));

  // R3: a hit is answered in the following cycle
  p_fwd_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> fwd_valid);

  // R6: a stalled read is never forwarded
  p_stall_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |=> !fwd_valid);
endmodule

// File: tb/mem_operand_bypass_test.sv
`timescale 1ns/1ps
module mem_operand_bypass_test;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_valid, wb_commit, pipe_flush, rd_req, cache_wr_ready;
  logic [ADDR_W-1:0] wb_addr, rd_addr;
  logic [31:0] wb_data;
  logic [3:0]  wb_be, rd_be;
  logic wb_ready, fwd_valid, rd_stall, cache_rd_en, cache_wr_valid;
  logic [31:0] fwd_data, cache_wr_data;
  logic [ADDR_W-1:0] cache_rd_addr, cache_wr_addr;
  logic [3:0] cache_wr_be;

  always #10 clk = ~clk;  // 50 MHz

  mem_operand_bypass #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be),
    .wb_ready(wb_ready), .wb_commit(wb_commit), .pipe_flush(pipe_flush),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_be(rd_be),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .rd_stall(rd_stall),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
    .cache_wr_valid(cache_wr_valid), .cache_wr_addr(cache_wr_addr),
    .cache_wr_data(cache_wr_data), .cache_wr_be(cache_wr_be),
    .cache_wr_ready(cache_wr_ready)
  );

  // Reference model: pending writes in program order, plus memory contents
  logic [ADDR_W-1:0] q_addr[$];
  logic [31:0]       q_data[$];
  logic [3:0]        q_be[$];
  int                q_nc;
  logic [31:0]       mem [256];
  bit                held;

  int    n_checks = 0;
  int    n_err    = 0;
  string ctx      = "";
  bit    done     = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] at %0t: actual %h expected %h", req, ctx, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] w, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = w;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  // One cycle: inputs are already driven; check combinational outputs,
  // cross the edge, check the registered forward, then advance the model.
  task automatic step();
    bit full, push, found, inc_hit, hit, part, miss, cm, pop;
    int nmatch;
    logic [3:0] ybe;
    logic [31:0] yd, arch;
    string tg;
    #2;
    full = (q_addr.size() == DEPTH);
    push = wb_valid && !full && !pipe_flush;
    found = 0; nmatch = 0; ybe = '0; yd = '0; inc_hit = 0;
    arch = mem[rd_addr];
    foreach (q_addr[i]) begin
      if (q_addr[i] == rd_addr) begin
        found = 1; nmatch++; ybe = q_be[i]; yd = q_data[i];
        arch = merge(arch, q_data[i], q_be[i]);
      end
    end
    if (push && wb_addr == rd_addr) begin
      found = 1; nmatch++; ybe = wb_be; yd = wb_data; inc_hit = 1;
      arch = merge(arch, wb_data, wb_be);
    end
    hit  = rd_req && found && ((rd_be & ~ybe) == 4'h0);
    part = rd_req && found && !hit;
    miss = rd_req && !found;
    chk("R2", 32'(wb_ready), 32'(!full));
    chk("R4", 32'(cache_rd_en), 32'(miss));
    if (miss) chk("R4", 32'(cache_rd_addr), 32'(rd_addr));
    chk("R6", 32'(rd_stall), 32'(part));
    chk(held ? "R9" : "R8", 32'(cache_wr_valid), 32'(q_nc > 0));
    if (q_nc > 0) begin
      chk(held ? "R9" : "R8", 32'(cache_wr_addr), 32'(q_addr[0]));
      chk(held ? "R9" : "R8", cache_wr_data, q_data[0]);
      chk(held ? "R9" : "R8", 32'(cache_wr_be), 32'(q_be[0]));
    end
    tg = inc_hit ? "R7" : (nmatch > 1 ? "R5" : "R3");
    cm  = wb_commit && (q_nc < q_addr.size());
    pop = (q_nc > 0) && cache_wr_ready;
    held = (q_nc > 0) && !cache_wr_ready;
    @(posedge clk);
    #1;
    chk(tg, 32'(fwd_valid), 32'(hit));
    if (hit) begin
      chk(tg, fwd_data, yd & lanes(rd_be));
      chk(tg, fwd_data, arch & lanes(rd_be));
    end
    if (cm) q_nc++;
    if (pop) begin
      mem[q_addr[0]] = merge(mem[q_addr[0]], q_data[0], q_be[0]);
      void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_be.pop_front());
      q_nc--;
    end
    if (pipe_flush) begin
      while (q_addr.size() > q_nc) begin
        void'(q_addr.pop_back()); void'(q_data.pop_back()); void'(q_be.pop_back());
      end
    end else if (push) begin
      q_addr.push_back(wb_addr); q_data.push_back(wb_data); q_be.push_back(wb_be);
    end
  endtask

  task automatic cyc(bit wv, logic [ADDR_W-1:0] wa, logic [31:0] wd, logic [3:0] wbe,
                     bit cmt, bit fl, bit rq, logic [ADDR_W-1:0] ra, logic [3:0] rbe, bit rdy);
    @(negedge clk);
    wb_valid = wv; wb_addr = wa; wb_data = wd; wb_be = wbe;
    wb_commit = cmt; pipe_flush = fl;
    rd_req = rq; rd_addr = ra; rd_be = rbe; cache_wr_ready = rdy;
    step();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = '0;
    q_nc = 0; held = 0;
    rst_n = 1'b0;
    wb_valid = 0; wb_addr = '0; wb_data = '0; wb_be = '0; wb_commit = 0;
    pipe_flush = 0; rd_req = 0; rd_addr = '0; rd_be = '0; cache_wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    ctx = "R1 reset";
    chk("R1", 32'(wb_ready), 32'd1);
    chk("R1", 32'(cache_wr_valid), 32'd0);
    chk("R1", 32'(fwd_valid), 32'd0);
    chk("R1", 32'(cache_rd_en), 32'd0);
    chk("R1", 32'(rd_stall), 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    ctx = "R7 same-cycle pair";
    cyc(1, 8'd1, 32'h11223344, 4'hF, 0, 0, 1, 8'd1, 4'hF, 0);
    ctx = "R3 masked forward";
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd1, 4'h6, 0);
    ctx = "R5 youngest wins";
    cyc(1, 8'd1, 32'hAABBCCDD, 4'hF, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd1, 4'hF, 0);
    ctx = "R6 partial overlap";
    cyc(1, 8'd1, 32'h000000EE, 4'h1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd1, 4'h3, 0);
    ctx = "R4 miss";
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd2, 4'hF, 0);
    ctx = "R2 full";
    cyc(1, 8'd3, 32'h00000055, 4'hF, 0, 0, 0, 0, 0, 0);
    cyc(1, 8'd3, 32'h00000066, 4'hF, 0, 0, 1, 8'd3, 4'hF, 0);
    ctx = "R9 held write";
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ctx = "R8 ordered drain";
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd1, 4'hF, 1);
    ctx = "R10 flush";
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd3, 4'hF, 0);
    cyc(1, 8'd2, 32'h12345678, 4'hF, 1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd2, 4'hF, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd3, 4'hF, 0);
    ctx = "R8 drain all";
    repeat (6) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    ctx = "R8 commit ignored when none";
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    cyc(1, 8'd0, 32'hCAFEF00D, 4'hF, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'd0, 4'hC, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    ctx = "random";
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] wbe_r, rbe_r;
      wbe_r = 4'($urandom_range(1, 15));
      rbe_r = 4'($urandom_range(1, 15));
      cyc($urandom_range(0, 1) == 1, 8'($urandom_range(0, 3)), $urandom, wbe_r,
          $urandom_range(0, 9) < 3, $urandom_range(0, 31) == 0,
          $urandom_range(0, 9) < 6, 8'($urandom_range(0, 3)), rbe_r,
          $urandom_range(0, 1) == 1);
    end

    ctx = "final drain";
    repeat (12) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R8", 32'(cache_wr_valid), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule